// File: doc/BRIEF.md
# Paged ROM bank address decoder

This block decodes the 16-bit address bus of an 8-bit processor into active-low chip selects. The lower part of the address space, 0x0000 to 0x9FFF, is a banked window. A 4-bit page register steers that window onto one of five ROM devices. The processor loads the page register by writing to a page port. The upper part of the space, 0xA000 and above, is never banked. It holds a work RAM, a palette RAM, a fixed ROM and a few I/O ports.

Only page bit 2 takes part in the bank decode. Bit 3 is a mirror, and bits 1 and 0 have no effect on the selects. When bit 2 is set, the 0x8000 to 0x9FFF window is empty.

The block also does two small jobs on the bus. It produces the write strobe for a 4-bit-wide NVRAM, and a protect switch can block writes to the lowest quarter of that NVRAM. It also turns a keyed write to a watchdog port into a one-cycle clear pulse.

All selects are combinational from the address and the page register. They are qualified by `bus_valid`. The bus has no back-pressure: every valid cycle completes in one clock, so the block has no valid/ready handshake.

Top module: `membank_decoder`

## Requirements
- R1: After reset the page register holds 0. With the page at 0, a valid access at 0x9000 asserts rom_sel_n[4], and wd_clear is low.
- R2: A valid write (`bus_valid` and `wr_en`) to the page port 0xC800 loads wdata[3:0] into the page register at the clock edge. The new page affects the selects from the next cycle on.
- R3: With page bit 2 clear, a valid access asserts one ROM select according to the address:
  - rom_sel_n[0] for 0x0000–0x3FFF
  - rom_sel_n[2] for 0x4000–0x7FFF
  - rom_sel_n[4] for 0x8000–0x9FFF
- R4: With page bit 2 set, a valid access asserts one ROM select according to the address:
  - rom_sel_n[1] for 0x0000–0x3FFF
  - rom_sel_n[3] for 0x4000–0x7FFF
  - no ROM select for 0x8000–0x9FFF
- R5: Page bits 3, 1 and 0 have no effect on any select. Page 0x8 decodes like page 0x0, and page 0xC decodes like page 0x4.
- R6: At most one ROM select is low at any time. No ROM select is low for an address of 0xA000 or above.
- R7: A valid access selects a fixed region by address:
  - ram_sel_n for 0xA000–0xBFFF
  - pal_sel_n for 0xC000–0xC7FF
  - fix_sel_n for 0xE000–0xFFFF
- R8: hi_sel_n is low for every valid access in 0xA000–0xFFFF and high otherwise.
- R9: A valid write to the NVRAM range 0xCC00–0xCFFF drives nv_we_n low, with one exception. When protect_on is 1 and address bits 9:8 are 00, nv_we_n stays high. nv_wdata always equals wdata[3:0].
- R10: A valid write to the watchdog port 0xC801 whose data ANDed with 0x3E equals 0x14 makes wd_clear high for exactly the following cycle. Any other write leaves wd_clear low.
- R11: While bus_valid is low, every select and nv_we_n stays high, and neither the page register nor wd_clear changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is in progress |
| addr | input | 16 | Processor address |
| wdata | input | 8 | Processor write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| protect_on | input | 1 | 1 = NVRAM lower quarter write-protected |
| rom_sel_n | output | 5 | Banked ROM selects, active low; bit i selects ROM i+1 |
| ram_sel_n | output | 1 | Work RAM select, active low |
| pal_sel_n | output | 1 | Palette RAM select, active low |
| fix_sel_n | output | 1 | Fixed ROM select, active low |
| hi_sel_n | output | 1 | Combined 0xA000–0xFFFF select, active low |
| nv_we_n | output | 1 | NVRAM write enable, active low |
| nv_wdata | output | 4 | NVRAM write data |
| wd_clear | output | 1 | One-cycle watchdog clear pulse |

## Verification
The hardest case to reach from the ports is a page value whose ignored bits disagree with its decoded bit, followed by an access in the empty upper window. For R5 and R4 to show anything, a page write must first land, and a banked access must come on a later cycle. The stimulus therefore mixes random page writes of all sixteen values with random banked accesses. It also replays directed writes of 0x8, 0xC, 0x3 and 0xB, each followed by probes of all three windows. Watchdog keys are drawn so that the masked-off bits 7, 6 and 0 vary while the key holds, and NVRAM writes straddle the quarter boundary with the switch in both states.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int PAGE_W   = 4;
  localparam int NUM_ROM  = 5;
  localparam int BANK_BIT = 2;
  localparam int NV_DW    = 4;
  localparam logic [15:0] PAGE_PORT = 16'hC800;
  localparam logic [15:0] WD_PORT   = 16'hC801;
  localparam logic [5:0]  NV_TAG    = 6'b110011;   // 0xCC00-0xCFFF
  localparam logic [7:0]  WD_MASK   = 8'h3E;
  localparam logic [7:0]  WD_KEY    = 8'h14;
endpackage

// File: rtl/mbd_page_reg.sv
module mbd_page_reg
  import mbd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PAGE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] page_q,
  output logic          wd_clear
);
  logic page_wr, wd_hit;

  assign page_wr = bus_valid && wr_en && (addr == AW'(PAGE_PORT));
  assign wd_hit  = bus_valid && wr_en && (addr == AW'(WD_PORT)) &&
                   ((wdata & DW'(WD_MASK)) == DW'(WD_KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      wd_clear <= 1'b0;
    end else begin
      if (page_wr) page_q <= wdata[PW-1:0];
      wd_clear <= wd_hit;
    end
  end

  // R2
  page_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && wr_en && addr == AW'(PAGE_PORT)) |=> page_q == $past(wdata[PW-1:0]));
  // R10
  wd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |-> $past(bus_valid && wr_en && addr == AW'(WD_PORT)));
  // R11
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> $stable(page_q) && !wd_clear);
endmodule

// File: rtl/mbd_bank_decode.sv
module mbd_bank_decode
  import mbd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PAGE_W,
  parameter int NR = NUM_ROM,
  parameter int BB = BANK_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] page_q,
  output logic [NR-1:0] rom_sel_n
);
  localparam int NWIN = (NR + 1) / 2;
  logic [2:0] win_hit;

  // windows: 16K, 16K, 8K
  assign win_hit[0] = (addr[AW-1:AW-2] == 2'b00);
  assign win_hit[1] = (addr[AW-1:AW-2] == 2'b01);
  assign win_hit[2] = (addr[AW-1:AW-3] == 3'b100);

  for (genvar i = 0; i < NR; i++) begin : g_rom
    localparam bit ODD = (i % 2) == 1;
    localparam int WIN = i / 2;
    assign rom_sel_n[i] = ~(bus_valid && win_hit[WIN] && (page_q[BB] == ODD));
  end

  // R6
  rom_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~rom_sel_n));
  // R6
  rom_high_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= AW'(16'hA000)) |-> &rom_sel_n);
  initial if (NWIN > 3) $error("too many ROM windows");
endmodule

// File: rtl/mbd_fixed_decode.sv
module mbd_fixed_decode
  import mbd_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NW = NV_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          protect_on,
  output logic          ram_sel_n,
  output logic          pal_sel_n,
  output logic          fix_sel_n,
  output logic          hi_sel_n,
  output logic          nv_we_n,
  output logic [NW-1:0] nv_wdata
);
  logic nv_hit, nv_low_q;

  assign ram_sel_n = ~(bus_valid && addr[AW-1:AW-3] == 3'b101);
  assign pal_sel_n = ~(bus_valid && addr[AW-1:AW-5] == 5'b11000);
  assign fix_sel_n = ~(bus_valid && addr[AW-1:AW-3] == 3'b111);
  assign hi_sel_n  = ~(bus_valid && addr[AW-1] && (addr[AW-2] || addr[AW-3]));

  assign nv_hit   = addr[AW-1:AW-6] == NV_TAG;
  assign nv_low_q = addr[9:8] == 2'b00;
  assign nv_we_n  = ~(bus_valid && wr_en && nv_hit && !(protect_on && nv_low_q));
  assign nv_wdata = wdata[NW-1:0];

  // R9
  nv_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (protect_on && addr[9:8] == 2'b00) |-> nv_we_n);
  // R8
  hi_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_sel_n || !pal_sel_n || !fix_sel_n) |-> !hi_sel_n);
endmodule

// File: rtl/membank_decoder.sv
module membank_decoder
  import mbd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic                protect_on,
  output logic [NUM_ROM-1:0]  rom_sel_n,
  output logic                ram_sel_n,
  output logic                pal_sel_n,
  output logic                fix_sel_n,
  output logic                hi_sel_n,
  output logic                nv_we_n,
  output logic [NV_DW-1:0]    nv_wdata,
  output logic                wd_clear
);
  logic [PAGE_W-1:0] page_q;
  logic              rd_unused;
  assign rd_unused = rd_en;

  mbd_page_reg u_page (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .page_q(page_q), .wd_clear(wd_clear)
  );

  mbd_bank_decode u_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr),
    .page_q(page_q), .rom_sel_n(rom_sel_n)
  );

  mbd_fixed_decode u_fixed (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .protect_on(protect_on),
    .ram_sel_n(ram_sel_n), .pal_sel_n(pal_sel_n), .fix_sel_n(fix_sel_n),
    .hi_sel_n(hi_sel_n), .nv_we_n(nv_we_n), .nv_wdata(nv_wdata)
  );

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (&rom_sel_n && ram_sel_n && pal_sel_n && fix_sel_n &&
                    hi_sel_n && nv_we_n));
endmodule

// File: tb/membank_decoder_tb_top.sv
module membank_decoder_tb_top;
  logic clk = 0, rst_n = 0, bus_valid = 0, wr_en = 0, rd_en = 0, protect_on = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [4:0]  rom_sel_n;
  logic ram_sel_n, pal_sel_n, fix_sel_n, hi_sel_n, nv_we_n, wd_clear;
  logic [3:0]  nv_wdata;
  int checks = 0, fails = 0;
  logic [3:0] exp_page = 0;
  logic exp_wd = 0;

  always #4 clk = ~clk;

  membank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .protect_on(protect_on), .rom_sel_n(rom_sel_n),
    .ram_sel_n(ram_sel_n), .pal_sel_n(pal_sel_n), .fix_sel_n(fix_sel_n),
    .hi_sel_n(hi_sel_n), .nv_we_n(nv_we_n), .nv_wdata(nv_wdata), .wd_clear(wd_clear)
  );

  function automatic logic [4:0] f_rom(input logic [15:0] a, input logic [3:0] p, input logic v);
    logic [4:0] s = 5'b11111;
    if (v) begin
      if (a < 16'h4000)      s[p[2] ? 1 : 0] = 1'b0;
      else if (a < 16'h8000) s[p[2] ? 3 : 2] = 1'b0;
      else if (a < 16'hA000 && !p[2]) s[4] = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [3:0] f_fixed(input logic [15:0] a, input logic v);
    // {ram, pal, fix, hi} active low
    return {~(v && a >= 16'hA000 && a <= 16'hBFFF), ~(v && a >= 16'hC000 && a <= 16'hC7FF),
            ~(v && a >= 16'hE000), ~(v && a >= 16'hA000)};
  endfunction

  function automatic logic f_nvwe(input logic [15:0] a, input logic v, input logic w, input logic pr);
    return ~(v && w && a >= 16'hCC00 && a <= 16'hCFFF && !(pr && a[9:8] == 2'b00));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (addr=%04h page=%0h)", req, act, exp, addr, exp_page);
    end
  endtask

  // drive at negedge, check combinational outputs, then clock
  task automatic cyc(input logic v, input logic [15:0] a, input logic w, input logic [7:0] d,
                     input logic pr, input string req);
    @(negedge clk);
    bus_valid = v; addr = a; wr_en = w; rd_en = v && !w; wdata = d; protect_on = pr;
    #1;
    chk({req, " wd"}, {31'd0, wd_clear}, {31'd0, exp_wd});
    chk({req, " rom"}, {27'd0, rom_sel_n}, {27'd0, f_rom(a, exp_page, v)});
    chk({req, " fixed"}, {28'd0, ram_sel_n, pal_sel_n, fix_sel_n, hi_sel_n}, {28'd0, f_fixed(a, v)});
    chk({req, " nvwe"}, {31'd0, nv_we_n}, {31'd0, f_nvwe(a, v, w, pr)});
    chk({req, " nvdata"}, {28'd0, nv_wdata}, {28'd0, d[3:0]});
    @(posedge clk);
    exp_wd = v && w && a == 16'hC801 && ((d & 8'h3E) == 8'h14);
    if (v && w && a == 16'hC800) exp_page = d[3:0];
  endtask

  task automatic probe_windows(input string req);
    cyc(1, 16'h1234, 0, 0, 0, req);
    cyc(1, 16'h5678, 0, 0, 0, req);
    cyc(1, 16'h9ABC, 0, 0, 0, req);
    cyc(1, 16'h9FFF, 0, 0, 0, req);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    #1;
    chk("R1 reset wd", {31'd0, wd_clear}, 0);
    rst_n = 1;
    // R1: page is 0 after reset -> ROM5 at 0x9000
    cyc(1, 16'h9000, 0, 0, 0, "R1");
    cyc(0, 16'h0000, 0, 0, 0, "R11 idle");
    // R11: idle write to page port must not load it
    cyc(0, 16'hC800, 1, 8'h04, 0, "R11");
    probe_windows("R11 page held");
    // R3 / R4 / R2
    cyc(1, 16'hC800, 1, 8'hF4, 0, "R2");
    probe_windows("R4");
    cyc(1, 16'hC800, 1, 8'h00, 0, "R2");
    probe_windows("R3");
    // R5 mirrors and ignored bits
    cyc(1, 16'hC800, 1, 8'h08, 0, "R2"); probe_windows("R5 page8");
    cyc(1, 16'hC800, 1, 8'h0C, 0, "R2"); probe_windows("R5 pageC");
    cyc(1, 16'hC800, 1, 8'h03, 0, "R2"); probe_windows("R5 page3");
    cyc(1, 16'hC800, 1, 8'h0B, 0, "R2"); probe_windows("R5 pageB");
    cyc(1, 16'hC800, 1, 8'h07, 0, "R2"); probe_windows("R5 page7");
    // R6/R7/R8 boundaries
    cyc(1, 16'hA000, 0, 0, 0, "R7 R8");
    cyc(1, 16'hBFFF, 0, 0, 0, "R7");
    cyc(1, 16'hC7FF, 0, 0, 0, "R7");
    cyc(1, 16'hD000, 0, 0, 0, "R8");
    cyc(1, 16'hE000, 0, 0, 0, "R7 R6");
    cyc(1, 16'hFFFF, 0, 0, 0, "R7 R6");
    // R9 protect boundary
    cyc(1, 16'hCC00, 1, 8'h5A, 1, "R9 blocked");
    cyc(1, 16'hCCFF, 1, 8'h5A, 1, "R9 blocked");
    cyc(1, 16'hCD00, 1, 8'hA5, 1, "R9 upper");
    cyc(1, 16'hCC00, 1, 8'h3C, 0, "R9 unprot");
    cyc(1, 16'hCFFF, 1, 8'h3C, 1, "R9 top");
    // R10 watchdog keys
    cyc(1, 16'hC801, 1, 8'h14, 0, "R10");
    cyc(1, 16'h0000, 0, 0, 0, "R10 pulse");
    cyc(1, 16'h0000, 0, 0, 0, "R10 end");
    cyc(1, 16'hC801, 1, 8'hD5, 0, "R10 masked");
    cyc(1, 16'hC801, 1, 8'h16, 0, "R10 bad key");
    cyc(1, 16'hC801, 0, 8'h14, 0, "R10 read");
    cyc(0, 16'hC801, 1, 8'h14, 0, "R10 R11");
    cyc(1, 16'h0000, 0, 0, 0, "R10 none");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [7:0] d;
      int k = $urandom_range(0, 9);
      d = 8'($urandom);
      case (k)
        0: a = 16'hC800;
        1: begin a = 16'hC801; d = (d & 8'hC1) | ($urandom_range(0,1) ? 8'h14 : (d & 8'h3E)); end
        2: a = 16'hCC00 | 16'($urandom_range(0, 1023));
        3, 4, 5: a = 16'($urandom_range(0, 16'h9FFF));
        default: a = 16'($urandom);
      endcase
      cyc(1'($urandom_range(0, 7) != 0), a, 1'($urandom), d, 1'($urandom),
          "R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule